// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block sits between a host CPU and the memories of a tile-and-sprite video processor. The CPU sees a small window of byte registers selected by a three-bit offset. Two of them give access to a 256-byte sprite attribute memory that has its own address space. Two more give access to a 14-bit video memory space. The video address is loaded with two byte writes. Each access through the video data register then steps the address by one.

Video addresses whose top six bits are all ones (the $3F00-$3FFF page) are served by a colour palette store inside the block, but only while rendering is off. That store has 32 visible slots backed by 28 bytes. Palette accesses finish without any external cycle. Every other video access, and any access made while rendering is on, runs a request/acknowledge transaction on the external video bus. Reads that use the external bus are answered from a read buffer filled by the previous such read. The buffer is then refilled from the bus.

A sprite DMA sequencer, started by a pulse, pulls 256 source bytes one per cycle. It pushes them through the sprite data path starting at the current sprite address. The CPU port is held off while the DMA runs.

Top module: `vpp_regport`

## Requirements
- R1: After reset the sprite address, the video address, the write toggle, the read buffer and all sprite bytes are zero, `cpu_ready` is 1 and `vbus_req` is 0.
- R2: A write to offset 3 loads the sprite address. A write to offset 4 stores the byte at that address and then adds one to the address, modulo 256. A read of offset 4 returns the byte at the address and leaves the address unchanged. Read data appears with `cpu_rvalid` in the cycle after acceptance.
- R3: For sprite bytes whose index modulo 4 equals 2, bits 4:2 are not stored and always read as 0.
- R4: Writes to offset 6 alternate between the high byte and the low byte, starting with the high byte. Only the low six bits of the high byte are kept, so the video address stays 14 bits.
- R5: Every accepted access to offset 7 adds one to the video address, wrapping from $3FFF to $0000.
- R6: While `rendering_on` is 0 and the video address is in $3F00-$3FFF, an access to offset 7 uses the internal palette and raises no `vbus_req`. A palette read returns the stored byte in that same access.
- R7: Palette slots repeat every 32 addresses across the $3Fxx page. Slots $10, $14, $18 and $1C share storage with $00, $04, $08 and $0C. All other slots are independent.
- R8: A read of offset 7 that uses the external bus returns the current read buffer. It then holds `vbus_req` with `vbus_we`=0 and a stable address until `vbus_ack`, and loads `vbus_rdata` into the buffer.
- R9: A write of offset 7 that uses the external bus drives `vbus_we`=1 with the address and data. `cpu_ready` stays 0 from acceptance until the cycle after `vbus_ack`.
- R10: While `rendering_on` is 1, offset 7 accesses in $3Fxx use the external bus like any other address.
- R11: A `dma_start` pulse accepted while idle performs 256 sprite writes, one per cycle. Each write stores `dma_data` for the source index shown on `dma_idx`, starting at the current sprite address and wrapping. The sprite address ends where it started, and `cpu_ready` is 0 throughout.
- R12: Writes to offsets 0, 1, 2 and 5 change nothing. Reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 3 | Register offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_ready | output | 1 | Port can accept an access |
| cpu_rvalid | output | 1 | Read data valid, one cycle after read acceptance |
| cpu_rdata | output | 8 | CPU read data |
| rendering_on | input | 1 | Rendering active; disables the palette intercept |
| dma_start | input | 1 | Start a sprite DMA burst |
| dma_req | output | 1 | DMA burst in progress; `dma_data` is consumed this cycle |
| dma_idx | output | 8 | Source byte index of the current DMA beat |
| dma_data | input | 8 | Source byte for `dma_idx` |
| vbus_req | output | 1 | External video bus request |
| vbus_we | output | 1 | External bus write enable |
| vbus_addr | output | 14 | External bus address |
| vbus_wdata | output | 8 | External bus write data |
| vbus_rdata | input | 8 | External bus read data, valid with `vbus_ack` |
| vbus_ack | input | 1 | External bus completion |

## Verification
The video data register is exercised with addresses in ordinary memory, addresses in the palette page with rendering off, and the same palette addresses with rendering on. This separates the internal intercept from the external path and from its rendering gate. Palette patterns write the primary slots, their mirrored partners, and copies of them 32 and more bytes higher in the page. This shows which slots share storage. Sprite patterns include address wrap, repeated reads, attribute bytes written with all ones, and a DMA that starts mid-memory. These show the increment rule, the missing bits and the wrap-around fill. Runs of consecutive buffered reads after known writes show the one-access lag of the read buffer.

// File: rtl/vpp_pkg.sv
package vpp_pkg;

   // CPU-visible register offsets; the numbering is part of the host contract
   typedef enum logic [2:0] {
      REG_SPR_ADDR = 3'd3,
      REG_SPR_DATA = 3'd4,
      REG_VID_ADDR = 3'd6,
      REG_VID_DATA = 3'd7
   } reg_sel_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUS  = 1'b1
   } bus_st_e;

   // folds a 32-entry palette index onto 28 stored bytes
   function automatic logic [4:0] pal_slot(input logic [4:0] idx);
      logic [4:0] j;
      j = {1'b0, idx[3:0]};
      if (!idx[4])
         return idx;
      else if (idx[1:0] == 2'b00)
         return j;
      else
         return 5'd15 + j - (j >> 2);
   endfunction

endpackage

// File: rtl/vpp_oam_store.sv
module vpp_oam_store #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 256,
   parameter bit ATTR_MASK = 1'b1,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic [AW-1:0]     addr_wdata,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data_wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [AW-1:0]     addr_q;
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= '0;
      else if (addr_we)
         addr_q <= addr_wdata;
      else if (data_we)
         addr_q <= addr_q + 1'b1;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      // attribute bytes lose their three unused middle bits
      localparam logic [DATA_W-1:0] KEEP =
         (ATTR_MASK && (g % 4 == 2)) ? ~DATA_W'(8'h1C) : '1;
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem_q[g] <= '0;
         else if (data_we && addr_q == AW'(g))
            mem_q[g] <= data_wdata & KEEP;
      end
   end

   assign rdata = mem_q[addr_q];

endmodule

// File: rtl/vpp_pal_store.sv
module vpp_pal_store #(
   parameter int DATA_W     = 8,
   parameter bit PAL_MIRROR = 1'b1,
   localparam int SLOTS     = PAL_MIRROR ? 28 : 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        idx,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   import vpp_pkg::*;

   logic [4:0]        slot;
   logic [DATA_W-1:0] mem_q [SLOTS];

   if (PAL_MIRROR) begin : g_fold
      assign slot = pal_slot(idx);
   end else begin : g_flat
      assign slot = idx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[slot] <= wdata;
      end
   end

   assign rdata = mem_q[slot];

endmodule

// File: rtl/vpp_dma_seq.sv
module vpp_dma_seq #(
   parameter int DATA_W = 8,
   parameter int LEN    = 256,
   localparam int CW    = $clog2(LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] data_in,
   output logic              busy,
   output logic [CW-1:0]     idx,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data
);

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CW'(LEN - 1)) busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end
   end

   assign busy    = busy_q;
   assign idx     = cnt_q;
   assign wr_en   = busy_q;
   assign wr_data = data_in;

endmodule

// File: rtl/vpp_regport.sv
module vpp_regport #(
   parameter int DATA_W     = 8,
   parameter int VADDR_W    = 14,
   parameter int OAM_DEPTH  = 256,
   parameter bit PAL_MIRROR = 1'b1,
   parameter bit ATTR_MASK  = 1'b1,
   localparam int OAM_AW    = $clog2(OAM_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [2:0]         cpu_reg,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic               cpu_ready,
   output logic               cpu_rvalid,
   output logic [DATA_W-1:0]  cpu_rdata,
   input  logic               rendering_on,
   input  logic               dma_start,
   output logic               dma_req,
   output logic [OAM_AW-1:0]  dma_idx,
   input  logic [DATA_W-1:0]  dma_data,
   output logic               vbus_req,
   output logic               vbus_we,
   output logic [VADDR_W-1:0] vbus_addr,
   output logic [DATA_W-1:0]  vbus_wdata,
   input  logic [DATA_W-1:0]  vbus_rdata,
   input  logic               vbus_ack
);
   import vpp_pkg::*;

   localparam int HI_W = VADDR_W - 8;

   if (DATA_W != 8) begin : g_bad_data
      $error("vpp_regport: DATA_W must be 8");
   end
   if (VADDR_W < 9 || VADDR_W > 16) begin : g_bad_vaddr
      $error("vpp_regport: VADDR_W must lie in 9..16");
   end
   if (OAM_DEPTH != (1 << OAM_AW) || OAM_AW > DATA_W) begin : g_bad_oam
      $error("vpp_regport: OAM_DEPTH must be a power of two no wider than a data byte");
   end

   bus_st_e            st_q;
   logic [VADDR_W-1:0] vaddr_q;
   logic               toggle_q;
   logic [DATA_W-1:0]  rd_buf_q;
   logic [VADDR_W-1:0] bus_addr_q;
   logic               bus_we_q;
   logic [DATA_W-1:0]  bus_wdata_q;
   logic               rvalid_q;
   logic [DATA_W-1:0]  rdata_q;

   logic              dma_busy, dma_wr;
   logic [DATA_W-1:0] dma_wdata;
   logic [DATA_W-1:0] oam_rdata, pal_rdata;

   logic accept, pal_hit, sel_vdata, dma_go;
   logic oam_addr_we, oam_data_we;
   logic [DATA_W-1:0] oam_wdata;

   assign cpu_ready = (st_q == ST_IDLE) && !dma_busy;
   assign accept    = cpu_req && cpu_ready;
   assign sel_vdata = accept && (cpu_reg == REG_VID_DATA);
   assign pal_hit   = !rendering_on && (&vaddr_q[VADDR_W-1:8]);
   assign dma_go    = dma_start && cpu_ready && !accept;

   assign oam_addr_we = accept && cpu_we && (cpu_reg == REG_SPR_ADDR);
   assign oam_data_we = dma_wr || (accept && cpu_we && (cpu_reg == REG_SPR_DATA));
   assign oam_wdata   = dma_wr ? dma_wdata : cpu_wdata;

   vpp_oam_store #(
      .DATA_W(DATA_W), .DEPTH(OAM_DEPTH), .ATTR_MASK(ATTR_MASK)
   ) i_oam (
      .clk(clk), .rst_n(rst_n),
      .addr_we(oam_addr_we), .addr_wdata(cpu_wdata[OAM_AW-1:0]),
      .data_we(oam_data_we), .data_wdata(oam_wdata),
      .rdata(oam_rdata)
   );

   vpp_pal_store #(
      .DATA_W(DATA_W), .PAL_MIRROR(PAL_MIRROR)
   ) i_pal (
      .clk(clk), .rst_n(rst_n),
      .idx(vaddr_q[4:0]),
      .we(sel_vdata && cpu_we && pal_hit),
      .wdata(cpu_wdata),
      .rdata(pal_rdata)
   );

   vpp_dma_seq #(
      .DATA_W(DATA_W), .LEN(OAM_DEPTH)
   ) i_dma (
      .clk(clk), .rst_n(rst_n),
      .start(dma_go), .data_in(dma_data),
      .busy(dma_busy), .idx(dma_idx),
      .wr_en(dma_wr), .wr_data(dma_wdata)
   );

   // register access, video address and external bus sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         vaddr_q     <= '0;
         toggle_q    <= 1'b0;
         rd_buf_q    <= '0;
         bus_addr_q  <= '0;
         bus_we_q    <= 1'b0;
         bus_wdata_q <= '0;
         rvalid_q    <= 1'b0;
         rdata_q     <= '0;
      end else begin
         rvalid_q <= accept && !cpu_we;
         if (accept && !cpu_we) begin
            if (cpu_reg == REG_SPR_DATA)
               rdata_q <= oam_rdata;
            else if (cpu_reg == REG_VID_DATA)
               rdata_q <= pal_hit ? pal_rdata : rd_buf_q;
            else
               rdata_q <= '0;
         end
         if (accept && cpu_we && cpu_reg == REG_VID_ADDR) begin
            toggle_q <= !toggle_q;
            if (!toggle_q)
               vaddr_q[VADDR_W-1:8] <= cpu_wdata[HI_W-1:0];
            else
               vaddr_q[7:0] <= cpu_wdata;
         end
         if (sel_vdata) begin
            vaddr_q <= vaddr_q + 1'b1;
            if (!pal_hit) begin
               st_q        <= ST_BUS;
               bus_addr_q  <= vaddr_q;
               bus_we_q    <= cpu_we;
               bus_wdata_q <= cpu_wdata;
            end
         end
         if (st_q == ST_BUS && vbus_ack) begin
            st_q <= ST_IDLE;
            if (!bus_we_q) rd_buf_q <= vbus_rdata;
         end
      end
   end

   assign cpu_rvalid = rvalid_q;
   assign cpu_rdata  = rdata_q;
   assign dma_req    = dma_busy;
   assign vbus_req   = (st_q == ST_BUS);
   assign vbus_we    = bus_we_q;
   assign vbus_addr  = bus_addr_q;
   assign vbus_wdata = bus_wdata_q;

endmodule

// File: rtl/vpp_regport_chk.sv
module vpp_regport_chk #(
   parameter int VADDR_W = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_req,
   input logic               cpu_we,
   input logic [2:0]         cpu_reg,
   input logic               cpu_ready,
   input logic               cpu_rvalid,
   input logic               rendering_on,
   input logic               dma_req,
   input logic               vbus_req,
   input logic               vbus_ack,
   input logic [VADDR_W-1:0] vbus_addr,
   input logic [VADDR_W-1:0] vaddr_q
);

   logic vd_acc;
   assign vd_acc = cpu_req && cpu_ready && (cpu_reg == 3'd7);

   assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> $past(cpu_req && cpu_ready && !cpu_we));

   assert_vaddr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vd_acc |=> (vaddr_q == VADDR_W'($past(vaddr_q) + 1'b1)));

   assert_pal_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vd_acc && !rendering_on && (&vaddr_q[VADDR_W-1:8])) |=> !vbus_req);

   assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vbus_req && !vbus_ack) |=> (vbus_req && $stable(vbus_addr)));

   assert_bus_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      vbus_req |-> !cpu_ready);

   assert_render_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (vd_acc && rendering_on) |=> vbus_req);

   assert_dma_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (!cpu_ready && !vbus_req));

endmodule

bind vpp_regport vpp_regport_chk #(.VADDR_W(VADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
   .cpu_reg(cpu_reg), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
   .rendering_on(rendering_on), .dma_req(dma_req), .vbus_req(vbus_req),
   .vbus_ack(vbus_ack), .vbus_addr(vbus_addr), .vaddr_q(vaddr_q)
);

// File: tb/test_vpp_regport.sv
module test_vpp_regport;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [2:0]  cpu_reg = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_ready, cpu_rvalid;
   logic [7:0]  cpu_rdata;
   logic        rendering_on = 1'b0;
   logic        dma_start = 1'b0;
   logic        dma_req;
   logic [7:0]  dma_idx, dma_data;
   logic        vbus_req, vbus_we;
   logic [13:0] vbus_addr;
   logic [7:0]  vbus_wdata;
   logic [7:0]  vbus_rdata = '0;
   logic        vbus_ack = 1'b0;

   vpp_regport i_vpp_regport (.*);

   always #(CLK_P/2) clk = ~clk;

   assign dma_data = dma_idx ^ 8'hC3;

   int n_cmp = 0, n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] vmem [int];
   int         bus_cnt = 0;
   logic [13:0] last_addr;
   logic        last_we;
   logic [7:0]  last_wdata, last_rdata;
   logic [7:0]  buf_m = '0;
   int          dma_beats = 0;
   bit          ended = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] vm_rd(input logic [13:0] a);
      if (vmem.exists(int'(a))) return vmem[int'(a)];
      return a[7:0] ^ {2'b00, a[13:8]};
   endfunction

   // external video memory model: acknowledges after three cycles of request
   initial begin
      int wait_n = 0;
      forever begin
         @(negedge clk);
         vbus_ack = 1'b0;
         if (vbus_req) begin
            wait_n++;
            if (wait_n == 3) begin
               wait_n = 0;
               bus_cnt++;
               last_addr = vbus_addr;
               last_we = vbus_we;
               if (vbus_we) begin
                  vmem[int'(vbus_addr)] = vbus_wdata;
                  last_wdata = vbus_wdata;
               end else begin
                  vbus_rdata = vm_rd(vbus_addr);
                  last_rdata = vbus_rdata;
               end
               vbus_ack = 1'b1;
            end
         end
      end
   end

   // monitor: read results against the scoreboard
   initial forever begin
      @(posedge clk); #1;
      if (rst_n && dma_req) dma_beats++;
      if (rst_n && cpu_rvalid) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: actual unexpected read %0h expected none", cpu_rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, cpu_rdata, e);
         end
      end
   end

   task automatic wait_idle();
      do @(negedge clk); while (!cpu_ready);
   endtask

   task automatic acc(input logic [2:0] r, input logic we, input logic [7:0] d,
                      input logic [7:0] exp, input string tag);
      wait_idle();
      if (!we) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
      cpu_req = 1'b1; cpu_we = we; cpu_reg = r; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic wr(input logic [2:0] r, input logic [7:0] d);
      acc(r, 1'b1, d, 8'h00, "");
   endtask

   task automatic rd(input logic [2:0] r, input logic [7:0] exp, input string tag);
      acc(r, 1'b0, 8'h00, exp, tag);
   endtask

   task automatic set_va(input logic [15:0] a);
      wr(3'd6, a[15:8]);
      wr(3'd6, a[7:0]);
   endtask

   // buffered external read of the video data register
   task automatic rd_ext(input logic [13:0] a, input string tag);
      int c0;
      c0 = bus_cnt;
      rd(3'd7, buf_m, tag);
      wait_idle();
      check({tag, " bus count"}, bus_cnt, c0 + 1);
      check({tag, " bus addr"}, last_addr, a);
      check({tag, " bus we"}, last_we, 1'b0);
      buf_m = last_rdata;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ready", cpu_ready, 1'b1);
      check("R1 vbus_req", vbus_req, 1'b0);
      rd(3'd4, 8'h00, "R1 sprite byte");
      rd_ext(14'h0000, "R1 buffer");

      // R2 sprite writes, increment, read without increment
      wr(3'd3, 8'h10);
      wr(3'd4, 8'h11); wr(3'd4, 8'h22); wr(3'd4, 8'hFF); wr(3'd4, 8'h44);
      wr(3'd3, 8'h10);
      rd(3'd4, 8'h11, "R2 read");
      rd(3'd4, 8'h11, "R2 read no step");
      wr(3'd3, 8'h11);
      rd(3'd4, 8'h22, "R2 next");
      // R3 attribute byte masking
      wr(3'd3, 8'h12);
      rd(3'd4, 8'hE3, "R3 attr mask");
      wr(3'd3, 8'h13);
      rd(3'd4, 8'h44, "R3 non-attr");
      // R2 wrap modulo 256
      wr(3'd3, 8'hFF);
      wr(3'd4, 8'hAB); wr(3'd4, 8'hCD);
      wr(3'd3, 8'h00);
      rd(3'd4, 8'hCD, "R2 wrap");

      // R4 + R9 external write with masked high byte
      set_va(16'hE134);
      c0 = bus_cnt;
      wr(3'd7, 8'h77);
      wait_idle();
      check("R9 bus count", bus_cnt, c0 + 1);
      check("R4 addr mask", last_addr, 14'h2134);
      check("R9 we", last_we, 1'b1);
      check("R9 data", last_wdata, 8'h77);
      // R5 step
      wr(3'd7, 8'h78);
      wait_idle();
      check("R5 step", last_addr, 14'h2135);

      // R8 buffered reads lag by one access
      set_va(16'h2134);
      rd_ext(14'h2134, "R8 first");
      check("R8 buffer fill", buf_m, 8'h77);
      rd_ext(14'h2135, "R8 second");
      rd_ext(14'h2136, "R8 third");

      // R6 palette intercept
      c0 = bus_cnt;
      set_va(16'h3F00);
      wr(3'd7, 8'h0A);
      set_va(16'h3F00);
      rd(3'd7, 8'h0A, "R6 palette read");
      wait_idle();
      check("R6 no bus", bus_cnt, c0);

      // R7 mirroring
      set_va(16'h3F10); wr(3'd7, 8'h2B);
      set_va(16'h3F00); rd(3'd7, 8'h2B, "R7 10->00");
      set_va(16'h3F01); wr(3'd7, 8'h05);
      set_va(16'h3F11); wr(3'd7, 8'h16);
      set_va(16'h3F21); rd(3'd7, 8'h05, "R7 21->01");
      set_va(16'h3FF1); rd(3'd7, 8'h16, "R7 F1->11");
      set_va(16'h3F1C); wr(3'd7, 8'h3C);
      set_va(16'h3F0C); rd(3'd7, 8'h3C, "R7 1C->0C");
      wait_idle();
      check("R7 no bus", bus_cnt, c0);

      // R10 rendering on sends palette page outward
      rendering_on = 1'b1;
      set_va(16'h3F00);
      rd_ext(14'h3F00, "R10 render read");
      rendering_on = 1'b0;

      // R5 wrap from top of space
      set_va(16'h3FFF);
      wr(3'd7, 8'h01);
      rd_ext(14'h0000, "R5 wrap");

      // R11 DMA from mid-memory
      wr(3'd3, 8'h80);
      wait_idle();
      dma_beats = 0;
      dma_start = 1'b1;
      @(negedge clk);
      dma_start = 1'b0;
      check("R11 ready low", cpu_ready, 1'b0);
      wait_idle();
      check("R11 beats", dma_beats, 256);
      rd(3'd4, 8'hC3, "R11 start addr kept");
      wr(3'd3, 8'h7F); rd(3'd4, 8'h3C, "R11 last beat");
      wr(3'd3, 8'h06); rd(3'd4, 8'h41, "R11 wrapped attr");

      // R12 unused offsets
      set_va(16'h0100);
      wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd0, 8'h55);
      wr(3'd7, 8'h99);
      wait_idle();
      check("R12 vaddr untouched", last_addr, 14'h0100);
      wr(3'd3, 8'h40); wr(3'd1, 8'h99); wr(3'd4, 8'h55);
      wr(3'd3, 8'h40); rd(3'd4, 8'h55, "R12 sprite addr untouched");
      rd(3'd0, 8'h00, "R12 read off0");
      rd(3'd5, 8'h00, "R12 read off5");
      rd(3'd3, 8'h00, "R12 read off3");

      repeat (4) @(negedge clk);
      check("scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

endmodule